// File: doc/BRIEF.md
# USB SETUP Transaction Capture

This block takes in the control-request phase of USB control transfers for a device controller. The packet decoder in front of it presents a decoded SETUP token with its endpoint number. It then presents the data packet one byte per cycle, followed by an end strobe that carries the result of the CRC16 check. A control request is always accepted. A packet that is exactly ten bytes long (eight request bytes and two CRC bytes) and has a good CRC replaces whatever the capture buffer still holds. The block then signals an ACK handshake. Software drains the buffer one byte at a time through a data register that advances on each read.

When a packet is accepted, the block also records some details of the request. It keeps the endpoint number and the transfer direction. It also records whether a data stage follows, which it decodes from the length field. In the same cycle it tells the IN and OUT handlers to clear the stall state of that endpoint. Two events are provided: request-ready and bus-reset. Each has a pending bit that is cleared by writing 1 and an enable bit, and together they drive a single interrupt. The block also holds the 7-bit device address, which a bus reset returns to 0.

Register offsets (3-bit `reg_addr`): 0 data (read pops), 1 control, 2 status, 3 raw event levels, 4 event pending, 5 event enable, 6 device address.

Top module: `usb_setup_capture`

## Requirements
- R1: After reset, every readable register returns 0x00, and `hs_ack`, `stall_clr_valid`, `irq` and `dev_addr` are 0.
- R2: A packet is accepted only when all of these hold: it follows a token, it has exactly 10 bytes, and its end strobe (`rx_end`, in a cycle without `rx_valid`) has `rx_crc_ok`=1. On acceptance, `hs_ack` is high for exactly the one cycle after the end strobe, and pending bit 0 (request-ready) is set.
- R3: Reads at offset 0 return the accepted bytes in arrival order, and each read advances to the next byte. Reading an empty buffer returns 0x00 and changes nothing. Status bit 4 is 1 while bytes remain.
- R4: An accepted packet discards every unread byte of the previous one. The next read returns the new packet's first byte.
- R5: Status bits [3:0] hold the token endpoint of the last accepted packet. Bit 6 equals bit 7 of request byte 0 (1 means device-to-host). Bit 7 is 1 when the little-endian length in request bytes 6 and 7 is non-zero.
- R6: A packet with a bad CRC, or with any length other than 10 bytes, produces no ACK and no request-ready event. It leaves the buffer contents and the status unchanged.
- R7: `stall_clr_valid` pulses in the same cycle as `hs_ack`, with `stall_clr_ep` equal to the endpoint of the accepted token.
- R8: While `bus_reset` is high, pending bit 1 is set and the device address is forced to 0, and this takes priority over a write of the address in the same cycle.
- R9: Writing 1 to a pending bit (offset 4) clears it, but an event in the same cycle keeps the bit set. Offset 3 returns {`bus_reset`, buffer-not-empty} in bits [1:0], and writes to it have no effect.
- R10: `irq`, and status bit 5, are 1 exactly when some pending bit has its enable bit (offset 5) set.
- R11: Writing 1 to control bit 5 (offset 1) does all of the following: empties the buffer, clears the status fields and pending bit 0, and abandons a packet in progress, so that packet gets no ACK.
- R12: Offset 6 holds the 7-bit device address, which is written and read back and drives `dev_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | A SETUP token has been decoded |
| tok_ep | input | EP_W | Endpoint of the token |
| rx_valid | input | 1 | Packet byte valid |
| rx_byte | input | 8 | Packet byte |
| rx_end | input | 1 | End of data packet |
| rx_crc_ok | input | 1 | CRC16 good, sampled with `rx_end` |
| bus_reset | input | 1 | Bus reset condition level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hs_ack | output | 1 | Send ACK handshake |
| stall_clr_valid | output | 1 | Clear stall of an endpoint |
| stall_clr_ep | output | EP_W | Endpoint whose stall is cleared |
| dev_addr | output | ADDR_W | Device address |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted byte slot or a wrong read pointer shows up at offset 0 on the very next read, as a byte out of order or a stale byte from an earlier packet. A wrong acceptance decision shows up in the cycle after the end strobe: an ACK that is missing or spurious, or a stall-clear pulse that is missing or spurious. A wrong event bit or enable bit appears on `irq` in the same cycle, while header-decode errors appear in status bits 6 and 7 once the packet is accepted.

// File: rtl/usb_setup_pkg.sv
package usb_setup_pkg;
   typedef enum logic [2:0] {
      REG_DATA   = 3'd0,
      REG_CTRL   = 3'd1,
      REG_STATUS = 3'd2,
      REG_LEVEL  = 3'd3,
      REG_PEND   = 3'd4,
      REG_EN     = 3'd5,
      REG_ADDR   = 3'd6
   } reg_sel_e;

   localparam int EV_READY       = 0;
   localparam int EV_BUSRST      = 1;
   localparam int NUM_EV         = 2;
   localparam int CTRL_FLUSH_BIT = 5;
   localparam int DIR_BYTE       = 0;
   localparam int LEN_LO_BYTE    = 6;
endpackage

// File: rtl/usb_setup_stage.sv
module usb_setup_stage #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 10,
   parameter int EP_W   = 4
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    abort,
   input  logic                    tok_valid,
   input  logic [EP_W-1:0]         tok_ep,
   input  logic                    rx_valid,
   input  logic [DATA_W-1:0]       rx_byte,
   input  logic                    rx_end,
   input  logic                    rx_crc_ok,
   output logic                    commit,
   output logic [DEPTH*DATA_W-1:0] stage_flat,
   output logic [EP_W-1:0]         stage_ep
);
   localparam int CNT_W = $clog2(DEPTH + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(DEPTH + 1);

   logic             armed;
   logic [CNT_W-1:0] cnt;
   logic             take;

   // a byte is stored only inside an open packet and when nothing of higher rank happens
   assign take = armed && rx_valid && !abort && !tok_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         cnt      <= '0;
         stage_ep <= '0;
      end else if (abort) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (tok_valid) begin
         armed    <= 1'b1;
         cnt      <= '0;
         stage_ep <= tok_ep;
      end else if (take) begin
         if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end else if (rx_end) begin
         armed <= 1'b0;
      end
   end

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_slot
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                            q <= '0;
            else if (take && cnt == CNT_W'(g))     q <= rx_byte;
         end
         assign stage_flat[g*DATA_W +: DATA_W] = q;
      end
   endgenerate

   assign commit = armed && rx_end && !rx_valid && !abort && !tok_valid
                   && rx_crc_ok && (cnt == CNT_FULL);
endmodule

// File: rtl/usb_setup_fifo.sv
module usb_setup_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 10
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [DEPTH*DATA_W-1:0] load_flat,
   input  logic                    flush,
   input  logic                    pop,
   output logic [DATA_W-1:0]       head,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                    have
);
   localparam int PTR_W = $clog2(DEPTH + 1);
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic [DEPTH*DATA_W-1:0] mem_flat;
   logic [PTR_W-1:0]        rd_ptr;

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_cell
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= load_flat[g*DATA_W +: DATA_W];
         end
         assign mem_flat[g*DATA_W +: DATA_W] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rd_ptr <= '0;
         level  <= '0;
      end else if (load) begin
         rd_ptr <= '0;
         level  <= LVL_W'(DEPTH);
      end else if (pop && have) begin
         rd_ptr <= rd_ptr + 1'b1;
         level  <= level - 1'b1;
      end
   end

   assign have = (level != '0);

   always_comb begin
      head = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (have && rd_ptr == PTR_W'(i)) head = mem_flat[i*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/usb_setup_events.sv
module usb_setup_events #(
   parameter int NUM_EV = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] ev_set,
   input  logic              w1c_wr,
   input  logic [NUM_EV-1:0] w1c_mask,
   input  logic [NUM_EV-1:0] ev_kill,
   input  logic              en_wr,
   input  logic [NUM_EV-1:0] en_data,
   output logic [NUM_EV-1:0] pending,
   output logic [NUM_EV-1:0] enable,
   output logic              irq
);
   genvar g;
   generate
      for (g = 0; g < NUM_EV; g++) begin : g_ev
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= ev_set[g] | (q & ~(w1c_wr & w1c_mask[g]) & ~ev_kill[g]);
         end
         assign pending[g] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     enable <= '0;
      else if (en_wr) enable <= en_data;
   end

   assign irq = |(pending & enable);
endmodule

// File: rtl/usb_setup_capture.sv
module usb_setup_capture
   import usb_setup_pkg::*;
#(
   parameter int EP_W      = 4,
   parameter int ADDR_W    = 7,
   parameter int REQ_BYTES = 8,
   parameter int CRC_BYTES = 2,
   parameter int DATA_W    = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_valid,
   input  logic [EP_W-1:0]   tok_ep,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_end,
   input  logic              rx_crc_ok,
   input  logic              bus_reset,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              hs_ack,
   output logic              stall_clr_valid,
   output logic [EP_W-1:0]   stall_clr_ep,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              irq
);
   localparam int DEPTH = REQ_BYTES + CRC_BYTES;
   localparam int LVL_W = $clog2(DEPTH + 1);

   generate
      if (DATA_W != 8)          begin : g_bad_width  $error("register byte must be 8 bits"); end
      if (EP_W > 4 || EP_W < 1) begin : g_bad_ep     $error("endpoint field is 1..4 bits"); end
      if (REQ_BYTES < 8)        begin : g_bad_req    $error("request header needs 8 bytes"); end
      if (ADDR_W > DATA_W - 1)  begin : g_bad_addr   $error("address must fit a register"); end
   endgenerate

   logic                    ctrl_flush;
   logic                    commit;
   logic [DEPTH*DATA_W-1:0] stage_flat;
   logic [EP_W-1:0]         stage_ep;
   logic [DATA_W-1:0]       fifo_head;
   logic [LVL_W-1:0]        fifo_level;
   logic                    fifo_have;
   logic                    data_pop;
   logic [NUM_EV-1:0]       ev_pend;
   logic [NUM_EV-1:0]       ev_en;
   logic [NUM_EV-1:0]       ev_set;
   logic [NUM_EV-1:0]       ev_kill;
   logic [EP_W-1:0]         st_ep;
   logic                    st_dir;
   logic                    st_dstage;
   logic                    dec_dir;
   logic                    dec_dstage;

   assign ctrl_flush = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[CTRL_FLUSH_BIT];
   assign data_pop   = reg_rd && (reg_addr == REG_DATA);

   usb_setup_stage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .EP_W(EP_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .abort(ctrl_flush),
      .tok_valid(tok_valid), .tok_ep(tok_ep),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
      .commit(commit), .stage_flat(stage_flat), .stage_ep(stage_ep)
   );

   usb_setup_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .load(commit), .load_flat(stage_flat),
      .flush(ctrl_flush), .pop(data_pop),
      .head(fifo_head), .level(fifo_level), .have(fifo_have)
   );

   always_comb begin
      ev_set            = '0;
      ev_set[EV_READY]  = commit;
      ev_set[EV_BUSRST] = bus_reset;
      ev_kill           = '0;
      ev_kill[EV_READY] = ctrl_flush;
   end

   usb_setup_events #(.NUM_EV(NUM_EV)) u_events (
      .clk(clk), .rst_n(rst_n), .ev_set(ev_set),
      .w1c_wr(reg_wr && (reg_addr == REG_PEND)), .w1c_mask(reg_wdata[NUM_EV-1:0]),
      .ev_kill(ev_kill),
      .en_wr(reg_wr && (reg_addr == REG_EN)), .en_data(reg_wdata[NUM_EV-1:0]),
      .pending(ev_pend), .enable(ev_en), .irq(irq)
   );

   // header decode: direction from bit 7 of byte 0, data stage from the 16-bit length
   assign dec_dir    = stage_flat[DIR_BYTE*DATA_W + DATA_W - 1];
   assign dec_dstage = |stage_flat[LEN_LO_BYTE*DATA_W +: 2*DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n || ctrl_flush) begin
         st_ep     <= '0;
         st_dir    <= 1'b0;
         st_dstage <= 1'b0;
      end else if (commit) begin
         st_ep     <= stage_ep;
         st_dir    <= dec_dir;
         st_dstage <= dec_dstage;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_ack          <= 1'b0;
         stall_clr_valid <= 1'b0;
         stall_clr_ep    <= '0;
      end else begin
         hs_ack          <= commit;
         stall_clr_valid <= commit;
         if (commit) stall_clr_ep <= stage_ep;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || bus_reset)                    dev_addr <= '0;
      else if (reg_wr && reg_addr == REG_ADDR)    dev_addr <= reg_wdata[ADDR_W-1:0];
   end

   always_comb begin
      case (reg_sel_e'(reg_addr))
         REG_DATA:   reg_rdata = fifo_head;
         REG_STATUS: reg_rdata = {st_dstage, st_dir, irq, fifo_have, 4'(st_ep)};
         REG_LEVEL:  reg_rdata = 8'({bus_reset, fifo_have});
         REG_PEND:   reg_rdata = 8'(ev_pend);
         REG_EN:     reg_rdata = 8'(ev_en);
         REG_ADDR:   reg_rdata = 8'(dev_addr);
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/usb_setup_checks.sv
module usb_setup_checks #(
   parameter int ADDR_W = 7,
   parameter int LVL_W  = 4,
   parameter int DEPTH  = 10
)(
   input logic              clk,
   input logic              rst_n,
   input logic              hs_ack,
   input logic              stall_clr_valid,
   input logic              bus_reset,
   input logic [ADDR_W-1:0] dev_addr,
   input logic              irq,
   input logic [1:0]        ev_pend,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              flush
);
   assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |=> !hs_ack);
   assert_ack_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |-> ev_pend[0]);
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(DEPTH));
   assert_full_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |-> fifo_level == LVL_W'(DEPTH));
   assert_stall_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_clr_valid |-> hs_ack);
   assert_addr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_reset) |-> dev_addr == '0);
   assert_busrst_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> ev_pend[1]);
   assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_pend == 2'b00) |-> !irq);
   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush) |-> (fifo_level == '0 && !hs_ack));
endmodule

bind usb_setup_capture usb_setup_checks #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .hs_ack(hs_ack), .stall_clr_valid(stall_clr_valid),
   .bus_reset(bus_reset), .dev_addr(dev_addr), .irq(irq), .ev_pend(ev_pend),
   .fifo_level(fifo_level), .flush(ctrl_flush)
);

// File: tb/sim_usb_setup_capture.sv
module sim_usb_setup_capture;
   localparam int CLK_NS = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tok_valid = 1'b0;
   logic [3:0] tok_ep = '0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_end = 1'b0;
   logic       rx_crc_ok = 1'b0;
   logic       bus_reset = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       hs_ack;
   logic       stall_clr_valid;
   logic [3:0] stall_clr_ep;
   logic [6:0] dev_addr;
   logic       irq;

   usb_setup_capture u0 (
      .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
      .bus_reset(bus_reset), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hs_ack(hs_ack),
      .stall_clr_valid(stall_clr_valid), .stall_clr_ep(stall_clr_ep),
      .dev_addr(dev_addr), .irq(irq)
   );

   always #(CLK_NS/2) clk = ~clk;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   // behavioural reference
   logic [7:0] m_fifo[$];
   logic [7:0] m_stage[$];
   bit         m_armed;
   logic [3:0] m_sep, m_ep, m_stall_ep;
   bit         m_dir, m_ds, m_ack, m_acc, m_flush;
   logic [1:0] m_pend, m_en;
   logic [6:0] m_addr;
   logic [7:0] pkt[0:11];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fifo.delete(); m_stage.delete();
         m_armed = 0; m_sep = 0; m_ep = 0; m_stall_ep = 0;
         m_dir = 0; m_ds = 0; m_ack = 0; m_pend = 0; m_en = 0; m_addr = 0;
      end else begin
         m_acc   = 0;
         m_flush = reg_wr && reg_addr == 3'd1 && reg_wdata[5];
         if (m_flush) begin
            m_armed = 0; m_stage.delete();
         end else if (tok_valid) begin
            m_armed = 1; m_stage.delete(); m_sep = tok_ep;
         end else if (rx_valid) begin
            if (m_armed) m_stage.push_back(rx_byte);
         end else if (rx_end && m_armed) begin
            m_armed = 0;
            if (rx_crc_ok && m_stage.size() == 10) m_acc = 1;
         end
         if (m_acc) begin
            m_fifo = m_stage;
            m_ep   = m_sep;
            m_dir  = m_stage[0][7];
            m_ds   = (m_stage[6] != 8'h00) || (m_stage[7] != 8'h00);
         end else if (m_flush) begin
            m_fifo.delete(); m_ep = 0; m_dir = 0; m_ds = 0;
         end else if (reg_rd && reg_addr == 3'd0 && m_fifo.size() > 0) begin
            void'(m_fifo.pop_front());
         end
         if (reg_wr && reg_addr == 3'd4) m_pend = m_pend & ~reg_wdata[1:0];
         if (m_flush)   m_pend[0] = 1'b0;
         if (m_acc)     m_pend[0] = 1'b1;
         if (bus_reset) m_pend[1] = 1'b1;
         if (reg_wr && reg_addr == 3'd5) m_en = reg_wdata[1:0];
         if (bus_reset) m_addr = 0;
         else if (reg_wr && reg_addr == 3'd6) m_addr = reg_wdata[6:0];
         m_ack = m_acc;
         if (m_acc) m_stall_ep = m_sep;
      end
   end

   function automatic logic [7:0] m_rd(int a);
      bit have = m_fifo.size() > 0;
      case (a)
         0: return have ? m_fifo[0] : 8'h00;
         2: return {m_ds, m_dir, |(m_pend & m_en), have, m_ep};
         3: return {6'b0, bus_reset, have};
         4: return {6'b0, m_pend};
         5: return {6'b0, m_en};
         6: return {1'b0, m_addr};
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison of the registered outputs
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(hs_ack === m_ack, "R2 ack handshake", hs_ack, m_ack);
         chk(stall_clr_valid === m_ack, "R7 stall clear pulse", stall_clr_valid, m_ack);
         if (m_ack) chk(stall_clr_ep === m_stall_ep, "R7 stall clear endpoint", stall_clr_ep, m_stall_ep);
         chk(dev_addr === m_addr, "R8 R12 device address", dev_addr, m_addr);
         chk(irq === |(m_pend & m_en), "R10 irq", irq, |(m_pend & m_en));
      end
   end

   task automatic rd(int a, string req);
      @(negedge clk);
      reg_addr = 3'(a); reg_rd = 1'b1;
      #1;
      chk(reg_rdata === m_rd(a), req, reg_rdata, m_rd(a));
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(int a, logic [7:0] d);
      @(negedge clk);
      reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic send(logic [3:0] ep, int n, bit crc);
      @(negedge clk);
      tok_valid = 1'b1; tok_ep = ep;
      @(negedge clk);
      tok_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1; rx_byte = pkt[i];
         @(negedge clk);
      end
      rx_valid = 1'b0; rx_end = 1'b1; rx_crc_ok = crc;
      @(negedge clk);
      rx_end = 1'b0; rx_crc_ok = 1'b0;
      @(negedge clk);
   endtask

   task automatic load_pkt(logic [7:0] b0, logic [7:0] b6, logic [7:0] b7, logic [7:0] base);
      for (int i = 0; i < 12; i++) pkt[i] = base + 8'(i);
      pkt[0] = b0; pkt[6] = b6; pkt[7] = b7;
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(hs_ack === 1'b0 && irq === 1'b0 && dev_addr === 7'd0, "R1 outputs after reset", {hs_ack, irq, dev_addr}, 0);
      for (int a = 0; a < 7; a++) rd(a, "R1 register after reset");

      wr(5, 8'h03);
      // device-to-host request with length 0x0040
      load_pkt(8'h80, 8'h40, 8'h00, 8'h10);
      send(4'd0, 10, 1'b1);
      rd(4, "R2 ready pending");
      rd(2, "R5 status dir/data-stage/endpoint");
      rd(0, "R3 first byte");
      chk(m_fifo.size() == 9, "R3 one byte consumed", m_fifo.size(), 9);
      rd(0, "R3 second byte");
      rd(2, "R3 have bit");

      // host-to-device, zero length, endpoint 5: replaces unread bytes
      load_pkt(8'h00, 8'h00, 8'h00, 8'h50);
      send(4'd5, 10, 1'b1);
      rd(0, "R4 new packet first byte");
      rd(2, "R5 status endpoint 5 no data stage");
      // length only in high byte
      load_pkt(8'h21, 8'h00, 8'h01, 8'h60);
      send(4'd9, 10, 1'b1);
      rd(2, "R5 length high byte");

      // bad CRC, short and long packets
      wr(4, 8'h01);
      load_pkt(8'h80, 8'h12, 8'h00, 8'hA0);
      send(4'd3, 10, 1'b0);
      rd(4, "R6 no ready after bad crc");
      rd(2, "R6 status kept after bad crc");
      send(4'd3, 9, 1'b1);
      send(4'd3, 11, 1'b1);
      rd(2, "R6 status kept after wrong length");
      rd(0, "R6 contents kept");

      // level register and pending clear
      wr(3, 8'hFF);
      rd(3, "R9 level write ignored");
      rd(4, "R9 pending before clear");
      @(negedge clk); bus_reset = 1'b1;
      wr(4, 8'h02);
      rd(4, "R9 set wins over clear");
      rd(3, "R9 bus reset level");
      @(negedge clk); bus_reset = 1'b0;
      wr(4, 8'h02);
      rd(4, "R9 pending cleared");

      // address
      wr(6, 8'h2A);
      rd(6, "R12 address readback");
      @(negedge clk); bus_reset = 1'b1;
      wr(6, 8'h11);
      @(negedge clk); bus_reset = 1'b0;
      rd(6, "R8 address forced to zero");
      rd(4, "R8 reset event pending");

      // drain and underflow
      for (int i = 0; i < 11; i++) rd(0, "R3 drain");
      rd(0, "R3 empty read returns zero");
      rd(2, "R3 have clear when empty");

      // irq gating
      load_pkt(8'h80, 8'h08, 8'h00, 8'h30);
      send(4'd2, 10, 1'b1);
      wr(5, 8'h00);
      rd(2, "R10 pend bit masked");
      wr(5, 8'h01);
      rd(2, "R10 pend bit enabled");

      // flush mid-packet
      @(negedge clk); tok_valid = 1'b1; tok_ep = 4'd7;
      @(negedge clk); tok_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin rx_valid = 1'b1; rx_byte = 8'hC0 + 8'(i); @(negedge clk); end
      rx_valid = 1'b0;
      wr(1, 8'h20);
      for (int i = 0; i < 6; i++) begin rx_valid = 1'b1; rx_byte = 8'hD0 + 8'(i); @(negedge clk); end
      rx_valid = 1'b0; rx_end = 1'b1; rx_crc_ok = 1'b1;
      @(negedge clk); rx_end = 1'b0; rx_crc_ok = 1'b0;
      @(negedge clk);
      chk(hs_ack === 1'b0, "R11 no ack after flush", hs_ack, 0);
      rd(2, "R11 status cleared");
      rd(4, "R11 ready pending cleared");
      rd(0, "R11 buffer empty");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule